// File: doc/BRIEF.md
# Two-Level Polled Interrupt Arbiter

This block decides, on every machine cycle, whether the processor core should leave its instruction stream and make a hardware call into an interrupt service routine, and which routine to call. In this design one clock cycle is one machine cycle. The block has ten request sources: four external lines, two timers, a serial port, a PWM unit, a watchdog and an A/D converter. The serial request is the OR of its receive and transmit flags. Each source has an enable bit and a priority bit, and a single global enable gates all of them. External lines 0 and 1 are active-low pins. For each of them a mode bit selects level detection or falling-edge detection.

The choice is made fresh on every cycle from the current inputs. The high level wins over the low level. Within a level, ties go to the lower source index. The call is requested only on the last cycle of an instruction. It is never requested during an instruction that writes an interrupt control register, and never during a return from interrupt. It is also never requested while a routine of equal or higher level is in service. A request that is refused is not stored. The block keeps one in-service bit per level. The bit is set when the core acknowledges a call, and the core's return clears the highest set bit.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset, `call_req_o` is 0 and `insvc_o` is 2'b00.
- R2: `call_req_o` can be 1 only in a cycle where `last_cyc_i`=1, `ctrl_wr_i`=0, `reti_i`=0 and `glb_en_i`=1.
- R3: A source takes part in arbitration only if its bit in `src_en_i` is 1. The serial source (index 4) is pending when `ser_rx_i` or `ser_tx_i` is 1.
- R4: Source indices are: 0 ext line 0, 1 timer 0, 2 ext line 1, 3 timer 1, 4 serial, 5 ext line 2 (`xflag_i[0]`), 6 ext line 3 (`xflag_i[1]`), 7 PWM, 8 watchdog, 9 A/D. A source whose `src_hi_i` bit is 1 belongs to the high level. Any pending high-level source wins over every low-level source. Within a level, the lowest index wins. `call_vec_o` carries the winning index whenever `call_req_o` is 1.
- R5: `insvc_o[1]` is the high-level in-service bit and `insvc_o[0]` is the low-level bit. A high-level winner is requested only when `insvc_o[1]`=0. A low-level winner is requested only when `insvc_o`=2'b00.
- R6: When `call_ack_i`=1 and `call_req_o`=1 in the same cycle, the in-service bit for the winner's level is 1 from the next cycle on. `call_ack_i` has no effect while `call_req_o` is 0.
- R7: `reti_i`=1 for one cycle clears `insvc_o[1]` if it is set. Otherwise it clears `insvc_o[0]`. The change shows in the next cycle.
- R8: When `ext_edge_i[k]`=0 (level mode), ext line k (k=0,1) is pending in the same cycle that `ext_n_i[k]` is 0.
- R9: When `ext_edge_i[k]`=1 (edge mode), a 1-to-0 change of `ext_n_i[k]` between two consecutive samples sets a flag. The line is pending from the next cycle on. The flag holds after the pin returns high, and it clears in the cycle after that line's call is acknowledged.
- R10: A level or peripheral request that is refused and then withdrawn before the blocking condition ends is never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one machine cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 2 | External lines 0 and 1, active low |
| ext_edge_i | input | 2 | Mode of ext lines 0/1: 1 = falling edge, 0 = level |
| tmr_flag_i | input | 2 | Timer 0 and timer 1 overflow flags |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| xflag_i | input | 2 | External line 2 and 3 flags |
| pwm_flag_i | input | 1 | PWM flag |
| wdt_flag_i | input | 1 | Watchdog flag |
| adc_flag_i | input | 1 | A/D converter flag |
| src_en_i | input | 10 | Per-source enable, indexed as in R4 |
| glb_en_i | input | 1 | Global enable |
| src_hi_i | input | 10 | Per-source level, 1 = high |
| last_cyc_i | input | 1 | Current cycle is the last one of the instruction |
| ctrl_wr_i | input | 1 | Instruction writes an interrupt control register |
| reti_i | input | 1 | Instruction is a return from interrupt |
| call_ack_i | input | 1 | Core takes the requested call |
| call_req_o | output | 1 | Hardware call request |
| call_vec_o | output | 4 | Index of the winning source |
| insvc_o | output | 2 | In-service bits {high, low} |

## Verification
Most faults inside this block show at the ports in the same cycle. A wrong priority encoder or a wrong gating term gives a wrong `call_req_o` or `call_vec_o` while the inputs that provoke it are still applied. A stuck or mis-updated in-service bit shows on `insvc_o` one cycle after the ack or return. From then on it also blocks or wrongly allows later requests. An edge flag that is not captured, or is never cleared, appears as a missing or a repeated call for that line from the cycle after the edge or the ack. The bench compares every output with a behavioural model on every cycle, so any such fault is reported in the first cycle it becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC = 10;
  localparam int unsigned N_EXT = 2;
  localparam int unsigned N_LVL = 2;
  localparam int unsigned VEC_W = $clog2(N_SRC);

  // fixed tie order; index is also the vector number
  localparam int unsigned IDX_X0  = 0;
  localparam int unsigned IDX_T0  = 1;
  localparam int unsigned IDX_X1  = 2;
  localparam int unsigned IDX_T1  = 3;
  localparam int unsigned IDX_SER = 4;
  localparam int unsigned IDX_X2  = 5;
  localparam int unsigned IDX_X3  = 6;
  localparam int unsigned IDX_PWM = 7;
  localparam int unsigned IDX_WDT = 8;
  localparam int unsigned IDX_ADC = 9;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  typedef struct packed {
    logic             vld;
    lvl_e             lvl;
    logic [VEC_W-1:0] vec;
  } win_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_n_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic prev_q, flag_q, fall;
    assign fall = prev_q & ~pin_n_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b1;
        flag_q <= 1'b0;
      end else begin
        prev_q <= pin_n_i[k];
        // a fresh edge outranks a same-cycle clear
        if (edge_mode_i[k] && fall) flag_q <= 1'b1;
        else if (clr_i[k])          flag_q <= 1'b0;
      end
    end

    assign req_o[k] = edge_mode_i[k] ? flag_q : ~pin_n_i[k];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N = N_SRC,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] hi_i,
  output logic         vld_o,
  output logic         hi_o,
  output logic [W-1:0] vec_o
);
  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic [N-1:0] mask;
    logic [W-1:0] idx;
    logic         hit;
    assign mask = pend_i & ((l == 1) ? hi_i : ~hi_i);

    always_comb begin
      idx = '0;
      hit = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
        if (mask[i]) begin
          idx = W'(i);
          hit = 1'b1;
        end
      end
    end
  end

  assign vld_o = g_lvl[1].hit | g_lvl[0].hit;
  assign hi_o  = g_lvl[1].hit;
  assign vec_o = g_lvl[1].hit ? g_lvl[1].idx : g_lvl[0].idx;
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  lvl_e             take_lvl_i,
  input  logic             reti_i,
  output logic [N_LVL-1:0] insvc_o
);
  logic [N_LVL-1:0] svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= '0;
    end else if (reti_i) begin
      if (svc_q[LVL_HI]) svc_q[LVL_HI] <= 1'b0;
      else               svc_q[LVL_LO] <= 1'b0;
    end else if (take_i) begin
      svc_q[take_lvl_i] <= 1'b1;
    end
  end

  assign insvc_o = svc_q;
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_n_i,
  input  logic [N_EXT-1:0] ext_edge_i,
  input  logic [1:0]       tmr_flag_i,
  input  logic             ser_rx_i,
  input  logic             ser_tx_i,
  input  logic [1:0]       xflag_i,
  input  logic             pwm_flag_i,
  input  logic             wdt_flag_i,
  input  logic             adc_flag_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             glb_en_i,
  input  logic [N_SRC-1:0] src_hi_i,
  input  logic             last_cyc_i,
  input  logic             ctrl_wr_i,
  input  logic             reti_i,
  input  logic             call_ack_i,
  output logic             call_req_o,
  output logic [VEC_W-1:0] call_vec_o,
  output logic [N_LVL-1:0] insvc_o
);
  logic [N_EXT-1:0] ext_req, ext_clr;
  logic [N_SRC-1:0] pend, pend_en;
  logic             win_vld, win_hi, lvl_free, poll_ok, take;
  logic [VEC_W-1:0] win_vec;
  logic [N_LVL-1:0] svc;

  irq_edge_det #(.N(N_EXT)) i_edge (
    .clk_i, .rst_ni,
    .pin_n_i(ext_n_i), .edge_mode_i(ext_edge_i),
    .clr_i(ext_clr), .req_o(ext_req)
  );

  always_comb begin
    pend          = '0;
    pend[IDX_X0]  = ext_req[0];
    pend[IDX_T0]  = tmr_flag_i[0];
    pend[IDX_X1]  = ext_req[1];
    pend[IDX_T1]  = tmr_flag_i[1];
    pend[IDX_SER] = ser_rx_i | ser_tx_i;
    pend[IDX_X2]  = xflag_i[0];
    pend[IDX_X3]  = xflag_i[1];
    pend[IDX_PWM] = pwm_flag_i;
    pend[IDX_WDT] = wdt_flag_i;
    pend[IDX_ADC] = adc_flag_i;
  end

  assign pend_en = pend & src_en_i & {N_SRC{glb_en_i}};

  irq_arbiter #(.N(N_SRC)) i_arb (
    .pend_i(pend_en), .hi_i(src_hi_i),
    .vld_o(win_vld), .hi_o(win_hi), .vec_o(win_vec)
  );

  // equal or higher level in service blocks the winner
  assign lvl_free = win_hi ? ~svc[LVL_HI] : ~|svc;
  assign poll_ok  = last_cyc_i & ~ctrl_wr_i & ~reti_i;
  assign take     = call_req_o & call_ack_i;

  irq_svc_track i_svc (
    .clk_i, .rst_ni,
    .take_i(take), .take_lvl_i(win_hi ? LVL_HI : LVL_LO),
    .reti_i, .insvc_o(svc)
  );

  assign ext_clr[0] = take & (win_vec == VEC_W'(IDX_X0));
  assign ext_clr[1] = take & (win_vec == VEC_W'(IDX_X1));

  assign call_req_o = win_vld & lvl_free & poll_ok;
  assign call_vec_o = win_vec;
  assign insvc_o    = svc;
endmodule

// File: rtl/irq_poll_ctrl_chk.sv
module irq_poll_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EXT-1:0] ext_n_i,
  input logic [N_EXT-1:0] ext_edge_i,
  input logic [N_SRC-1:0] src_en_i,
  input logic             glb_en_i,
  input logic [N_SRC-1:0] src_hi_i,
  input logic             last_cyc_i,
  input logic             ctrl_wr_i,
  input logic             reti_i,
  input logic             call_ack_i,
  input logic             call_req_o,
  input logic [VEC_W-1:0] call_vec_o,
  input logic [N_LVL-1:0] insvc_o
);
  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> (last_cyc_i && !ctrl_wr_i && !reti_i && glb_en_i));

  p_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> src_en_i[call_vec_o]);

  p_vec_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> (call_vec_o < VEC_W'(N_SRC)));

  p_hi_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> !insvc_o[1]);

  p_lo_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && insvc_o[0]) |-> src_hi_i[call_vec_o]);

  p_ack_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && call_ack_i && src_hi_i[call_vec_o]) |=> insvc_o[1]);

  p_ack_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && call_ack_i && !src_hi_i[call_vec_o]) |=> insvc_o[0]);

  p_reti_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && insvc_o[1]) |=> (!insvc_o[1] && insvc_o[0] == $past(insvc_o[0])));

  p_reti_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && insvc_o == 2'b01) |=> (insvc_o == 2'b00));

  p_level_x0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_edge_i[0] && !ext_n_i[0] && src_en_i[0] && glb_en_i && last_cyc_i &&
     !ctrl_wr_i && !reti_i && insvc_o == 2'b00) |-> call_req_o);
endmodule

bind irq_poll_ctrl irq_poll_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_n_i(ext_n_i), .ext_edge_i(ext_edge_i),
  .src_en_i(src_en_i), .glb_en_i(glb_en_i), .src_hi_i(src_hi_i),
  .last_cyc_i(last_cyc_i), .ctrl_wr_i(ctrl_wr_i), .reti_i(reti_i),
  .call_ack_i(call_ack_i), .call_req_o(call_req_o), .call_vec_o(call_vec_o),
  .insvc_o(insvc_o)
);

// File: tb/test_irq_poll_ctrl.sv
module test_irq_poll_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] ext_n = 2'b11, ext_edge = 0, tmr = 0, xflag = 0;
  logic       ser_rx = 0, ser_tx = 0, pwm = 0, wdt = 0, adc = 0;
  logic [9:0] en = '1, hi = '0;
  logic       glb = 1, last = 1, wr = 0, reti = 0, ack = 0;
  logic       req;
  logic [3:0] vec;
  logic [1:0] insvc;

  irq_poll_ctrl i_irq_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_n_i(ext_n), .ext_edge_i(ext_edge),
    .tmr_flag_i(tmr), .ser_rx_i(ser_rx), .ser_tx_i(ser_tx), .xflag_i(xflag),
    .pwm_flag_i(pwm), .wdt_flag_i(wdt), .adc_flag_i(adc), .src_en_i(en),
    .glb_en_i(glb), .src_hi_i(hi), .last_cyc_i(last), .ctrl_wr_i(wr),
    .reti_i(reti), .call_ack_i(ack), .call_req_o(req), .call_vec_o(vec),
    .insvc_o(insvc)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  // model state
  bit m_hi = 0, m_lo = 0;
  bit [1:0] m_ef = 0, m_prev = 2'b11;
  bit ex_req; int ex_vec; bit ex_lv;

  task automatic model_eval();
    bit [9:0] p;
    bit found = 0;
    p[0] = ext_edge[0] ? m_ef[0] : !ext_n[0];
    p[1] = tmr[0];
    p[2] = ext_edge[1] ? m_ef[1] : !ext_n[1];
    p[3] = tmr[1];
    p[4] = ser_rx | ser_tx;
    p[5] = xflag[0];
    p[6] = xflag[1];
    p[7] = pwm; p[8] = wdt; p[9] = adc;
    ex_req = 0; ex_vec = 0; ex_lv = 0;
    for (int l = 1; l >= 0; l--)
      for (int i = 0; i < 10; i++)
        if (!found && glb && p[i] && en[i] && (hi[i] == l[0])) begin
          found = 1; ex_vec = i; ex_lv = l[0];
        end
    if (found && last && !wr && !reti && (ex_lv ? !m_hi : !(m_hi || m_lo)))
      ex_req = 1;
  endtask

  task automatic model_clock();
    if (reti) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end else if (ex_req && ack) begin
      if (ex_lv) m_hi = 1; else m_lo = 1;
    end
    for (int k = 0; k < 2; k++) begin
      if (ext_edge[k] && m_prev[k] && !ext_n[k]) m_ef[k] = 1;
      else if (ex_req && ack && ex_vec == 2*k) m_ef[k] = 0;
    end
    m_prev = ext_n;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one machine cycle: compare with model, optional literal expectation
  task automatic cyc(string tag, bit lit = 0, bit lr = 0, int lv = 0);
    #(CLK_P/4);
    model_eval();
    chk(tag, "req", int'(req), int'(ex_req));
    if (ex_req) chk(tag, "vec", int'(vec), ex_vec);
    chk(tag, "insvc", int'(insvc), int'({m_hi, m_lo}));
    if (lit) begin
      chk(tag, "req_lit", int'(req), int'(lr));
      if (lr) chk(tag, "vec_lit", int'(vec), lv);
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc("R1", 1, 0, 0);
    // R2 blocking conditions
    tmr[0] = 1;
    cyc("R2", 1, 1, 1);
    last = 0; cyc("R2", 1, 0, 0);
    last = 1; wr = 1; cyc("R2", 1, 0, 0);
    wr = 0; reti = 1; cyc("R2", 1, 0, 0);
    reti = 0; glb = 0; cyc("R2", 1, 0, 0);
    glb = 1; cyc("R2", 1, 1, 1);
    // R3 enables and serial OR
    en[1] = 0; cyc("R3", 1, 0, 0);
    en = '1; tmr = 0; ser_rx = 1; cyc("R3", 1, 1, 4);
    ser_rx = 0; ser_tx = 1; cyc("R3", 1, 1, 4);
    ser_tx = 0;
    // R4 level and order
    tmr = 2'b11; adc = 1; cyc("R4", 1, 1, 1);
    hi[9] = 1; cyc("R4", 1, 1, 9);
    hi[3] = 1; cyc("R4", 1, 1, 3);
    hi = 0; tmr = 0; adc = 0; xflag[0] = 1; pwm = 1; cyc("R4", 1, 1, 5);
    xflag = 0;
    // R6 / R5 acknowledge and level blocking
    ack = 1; cyc("R6", 1, 1, 7);
    ack = 0; cyc("R5", 1, 0, 0);
    wdt = 1; hi[8] = 1; cyc("R5", 1, 1, 8);
    ack = 1; cyc("R6", 1, 1, 8);
    ack = 0; cyc("R5", 1, 0, 0);
    // R7 return
    reti = 1; cyc("R7", 1, 0, 0);
    reti = 0; cyc("R7", 1, 1, 8);
    reti = 1; cyc("R7", 1, 0, 0);
    reti = 0; cyc("R7", 1, 1, 8);
    wdt = 0; hi = 0;
    // R6 ack without request ignored
    last = 0; ack = 1; cyc("R6", 1, 0, 0);
    ack = 0; cyc("R6", 1, 0, 0);
    last = 1; cyc("R6", 1, 1, 7);
    pwm = 0;
    // R8 level mode
    ext_n[0] = 0; cyc("R8", 1, 1, 0);
    ext_n[0] = 1; cyc("R8", 1, 0, 0);
    // R9 edge mode
    ext_edge[1] = 1; ext_n[1] = 0; cyc("R9", 1, 0, 0);
    cyc("R9", 1, 1, 2);
    last = 0; ext_n[1] = 1; cyc("R9", 1, 0, 0);
    cyc("R9", 1, 0, 0);
    last = 1; cyc("R9", 1, 1, 2);
    ack = 1; cyc("R9", 1, 1, 2);
    ack = 0; cyc("R9", 1, 0, 0);
    reti = 1; cyc("R9", 1, 0, 0);
    reti = 0; cyc("R9", 1, 0, 0);
    ext_edge = 0;
    // R10 refused request not remembered
    tmr[1] = 1; hi[3] = 1; ack = 1; cyc("R10", 1, 1, 3);
    ack = 0; tmr = 0; hi = 0; xflag[1] = 1; cyc("R10", 1, 0, 0);
    xflag = 0; reti = 1; cyc("R10", 1, 0, 0);
    reti = 0; cyc("R10", 1, 0, 0);
    cyc("R10", 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule